// File: doc/BRIEF.md
# Parallel Port Mode Negotiation Controller

This block is the host side of the IEEE 1284 mode handshake. It takes a parallel port out of compatibility mode and into an extended mode named by an extensibility byte. It can also run the reverse handshake that returns the peripheral to compatibility idle. It drives the 8-bit data lines and the four host control lines, and it watches the five peripheral status lines through a synchronizer. Data transfer phases are left to other logic. The block owns only the event sequence, the timeouts for each step and the decision to accept or refuse the mode.

A one-cycle `neg_req` starts a negotiation for the byte on `neg_mode`, and a one-cycle `term_req` starts a termination. Each operation ends with a single-cycle `done` and a two-bit `result`: 0 means accepted or terminated, 1 means refused, 2 means timed out and 3 means I/O error. Every wait is counted in ticks of a prescaled timebase, `PRESCALE` clocks per tick. The timebase restarts each time a wait begins. The setup time is `T_SETUP` ticks (default 1) and the response time is `T_RESP` ticks (default 6). With the defaults, the nibble request byte is 0x00 and the run-length-encoded ECP request byte is 0x30. Control and status pins are plain levels with no handshake. No data stream crosses the block's boundary, so no valid/ready interface is needed.

Top module: `p1284_negotiator`

## Requirements
- R1: After reset the host lines sit at compatibility idle: `host_strobe_n`, `host_feed_n` and `host_init_n` are 1, `host_sel_n` is 0, `pdata` is 0x00, and `done`, `active` and `ext_mode` are 0.
- R2: If `host_sel_n` is already 1 when a negotiation is requested, `done` rises on the next cycle with result 3 (I/O error). Neither the data lines nor any host control line changes.
- R3: A negotiation first places the mode byte on `pdata`, with `host_sel_n` still 0. After one setup tick it raises `host_sel_n` and lowers `host_feed_n`, while `host_strobe_n` and `host_init_n` stay 1.
- R4: The host then waits for `dev_paper_err`, `dev_online` and `dev_fault_n` all at 1 and `dev_ack_n` at 0. If they do not arrive within setup plus response ticks, the result is 2 (timed out). That result comes no sooner than (2·T_SETUP+T_RESP)·PRESCALE clocks after the request.
- R5: Once the peripheral has answered, `host_strobe_n` goes low for one tick (at least PRESCALE and at most PRESCALE+1 clocks). It then returns to 1 together with `host_feed_n`. The strobe is never low while `host_sel_n` is 0.
- R6: If `dev_ack_n` has not returned to 1 within setup plus response ticks after the strobe, the result is 3 (I/O error).
- R7: Mode byte 0x00 is accepted whatever `dev_online` shows. Any other byte is accepted (result 0) only if `dev_online` is 1 when `dev_ack_n` rises; otherwise the result is 1 (refused). On acceptance `ext_mode` becomes 1 and `host_sel_n` stays 1.
- R8: A refused or timed-out operation leaves `ext_mode` at 0 and the host control lines at compatibility idle.
- R9: A termination first drives `host_sel_n` to 0 and `host_feed_n` to 1. When `dev_busy` and `dev_fault_n` are both 1, it drives `host_feed_n` low, waits for `dev_ack_n` at 1, and then drives `host_feed_n` high. The result is 0 and `ext_mode` becomes 0.
- R10: If `dev_busy` and `dev_fault_n` do not both read 1 within setup plus response ticks, the termination ends at once with result 2, `ext_mode` at 0 and the lines at compatibility idle.
- R11: If `dev_ack_n` does not rise within the response time during termination, the result is 3. `host_feed_n` returns to 1 and `ext_mode` is 0.
- R12: `done` is high for exactly one clock per operation. Requests that arrive while an operation is running are ignored.
- R13: If `neg_req` and `term_req` are both raised in the same idle cycle, only the termination runs. `pdata` keeps its value and `host_sel_n` never rises.
- R14: `active` is 1 from the cycle after a request is taken until `done` is raised, and 0 whenever `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| neg_req | input | 1 | One-cycle request to negotiate |
| neg_mode | input | 8 | Extensibility byte for the negotiation |
| term_req | input | 1 | One-cycle request to terminate |
| active | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 refused, 2 timed out, 3 I/O error |
| ext_mode | output | 1 | Port is in the negotiated extended mode |
| pdata | output | 8 | Host data lines |
| host_strobe_n | output | 1 | Strobe line, active low |
| host_feed_n | output | 1 | Auto-feed line, active low |
| host_init_n | output | 1 | Initialise line, active low |
| host_sel_n | output | 1 | Select-in line, active low |
| dev_ack_n | input | 1 | Peripheral acknowledge, active low |
| dev_busy | input | 1 | Peripheral busy |
| dev_paper_err | input | 1 | Peripheral paper-error line |
| dev_online | input | 1 | Peripheral select line |
| dev_fault_n | input | 1 | Peripheral fault, active low |

## Verification
A negotiation request and a termination request can arrive in the same idle cycle. The bench raises both together against a peripheral that only answers a termination from extended mode. It judges the outcome by a result of 2, an unchanged data bus and `host_sel_n` staying low throughout. The same pair is also fired in the middle of a running negotiation. In that case the negotiation must still finish with acceptance, showing that both requests were ignored.

// File: rtl/p1284_pkg.sv
package p1284_pkg;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_REFUSED = 2'd1,
    RES_TIMEOUT = 2'd2,
    RES_IOERR   = 2'd3
  } res_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT_ANS,
    ST_LATCH,
    ST_WAIT_RESP,
    ST_TERM_WAIT,
    ST_TERM_HS
  } st_e;

  typedef struct packed {
    logic strobe_n;
    logic feed_n;
    logic init_n;
    logic sel_n;
  } hpins_t;

  localparam hpins_t PINS_IDLE = '{strobe_n: 1'b1, feed_n: 1'b1, init_n: 1'b1, sel_n: 1'b0};
  localparam hpins_t PINS_REQ  = '{strobe_n: 1'b1, feed_n: 1'b0, init_n: 1'b1, sel_n: 1'b1};

endpackage

// File: rtl/p1284_insync.sv
module p1284_insync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 5,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [WIDTH-1:0] pipe [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= RST_VAL;
        else        pipe[0] <= d;
      end
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[i] <= RST_VAL;
          else        pipe[i] <= pipe[i-1];
        end
      end
      assign q = pipe[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/p1284_tickgen.sv
module p1284_tickgen #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [W-1:0] LAST = W'(PRESCALE - 1);

  logic [W-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/p1284_waittimer.sv
module p1284_waittimer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic          expired
);
  logic [CW-1:0] cnt;

  assign expired = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (tick && cnt != 0) cnt <= cnt - 1'b1;
  end

  // A drained timer must stay drained until the next load (timeouts of R4).
  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/p1284_negotiator.sv
module p1284_negotiator
  import p1284_pkg::*;
#(
  parameter int          PRESCALE    = 4,
  parameter int          T_SETUP     = 1,
  parameter int          T_RESP      = 6,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  NIBBLE_CODE = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       neg_req,
  input  logic [7:0] neg_mode,
  input  logic       term_req,
  output logic       active,
  output logic       done,
  output logic [1:0] result,
  output logic       ext_mode,
  output logic [7:0] pdata,
  output logic       host_strobe_n,
  output logic       host_feed_n,
  output logic       host_init_n,
  output logic       host_sel_n,
  input  logic       dev_ack_n,
  input  logic       dev_busy,
  input  logic       dev_paper_err,
  input  logic       dev_online,
  input  logic       dev_fault_n
);
  localparam int T_LONG = T_SETUP + T_RESP;
  localparam int CW     = $clog2(T_LONG + 1);

  // synchronised peripheral status
  logic [4:0] dev_s;
  logic ack_n_s, busy_s, perr_s, onl_s, fault_n_s;

  p1284_insync #(.STAGES(SYNC_STAGES), .WIDTH(5), .RST_VAL(5'b10001)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({dev_ack_n, dev_busy, dev_paper_err, dev_online, dev_fault_n}),
    .q    (dev_s)
  );
  assign {ack_n_s, busy_s, perr_s, onl_s, fault_n_s} = dev_s;

  // event conditions
  logic ev_answer, ev_resp, ev_term_ack, ev_term_fin;
  assign ev_answer   = perr_s & onl_s & fault_n_s & ~ack_n_s;
  assign ev_resp     = ack_n_s;
  assign ev_term_ack = busy_s & fault_n_s;
  assign ev_term_fin = ack_n_s;

  // timebase and wait timer
  logic          ld;
  logic [CW-1:0] ld_val;
  logic          tick, expired;

  p1284_tickgen #(.PRESCALE(PRESCALE)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(ld),
    .tick   (tick)
  );

  p1284_waittimer #(.CW(CW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ld),
    .load_val(ld_val),
    .tick    (tick),
    .expired (expired)
  );

  // sequencer state
  st_e        st, st_n;
  hpins_t     pins, pins_n;
  logic [7:0] dout, dout_n;
  logic       done_q, done_n;
  res_e       res_q, res_n;
  logic       ext_q, ext_n;

  always_comb begin
    st_n   = st;
    pins_n = pins;
    dout_n = dout;
    done_n = 1'b0;
    res_n  = res_q;
    ext_n  = ext_q;
    ld     = 1'b0;
    ld_val = '0;
    case (st)
      ST_IDLE: begin
        if (term_req) begin
          pins_n = PINS_IDLE;
          ld     = 1'b1;
          ld_val = CW'(T_LONG);
          st_n   = ST_TERM_WAIT;
        end else if (neg_req) begin
          if (pins.sel_n) begin
            done_n = 1'b1;
            res_n  = RES_IOERR;
          end else begin
            dout_n = neg_mode;
            ld     = 1'b1;
            ld_val = CW'(T_SETUP);
            st_n   = ST_SETUP;
          end
        end
      end
      ST_SETUP: begin
        if (expired) begin
          pins_n = PINS_REQ;
          ld     = 1'b1;
          ld_val = CW'(T_LONG);
          st_n   = ST_WAIT_ANS;
        end
      end
      ST_WAIT_ANS: begin
        if (ev_answer) begin
          pins_n.strobe_n = 1'b0;
          ld     = 1'b1;
          ld_val = CW'(T_SETUP);
          st_n   = ST_LATCH;
        end else if (expired) begin
          pins_n = PINS_IDLE;
          done_n = 1'b1;
          res_n  = RES_TIMEOUT;
          ext_n  = 1'b0;
          st_n   = ST_IDLE;
        end
      end
      ST_LATCH: begin
        if (expired) begin
          pins_n.strobe_n = 1'b1;
          pins_n.feed_n   = 1'b1;
          ld     = 1'b1;
          ld_val = CW'(T_LONG);
          st_n   = ST_WAIT_RESP;
        end
      end
      ST_WAIT_RESP: begin
        if (ev_resp) begin
          done_n = 1'b1;
          st_n   = ST_IDLE;
          if (dout == NIBBLE_CODE || onl_s) begin
            res_n = RES_OK;
            ext_n = 1'b1;
          end else begin
            res_n  = RES_REFUSED;
            ext_n  = 1'b0;
            pins_n = PINS_IDLE;
          end
        end else if (expired) begin
          pins_n = PINS_IDLE;
          done_n = 1'b1;
          res_n  = RES_IOERR;
          ext_n  = 1'b0;
          st_n   = ST_IDLE;
        end
      end
      ST_TERM_WAIT: begin
        if (ev_term_ack) begin
          pins_n.feed_n = 1'b0;
          ld     = 1'b1;
          ld_val = CW'(T_RESP);
          st_n   = ST_TERM_HS;
        end else if (expired) begin
          pins_n = PINS_IDLE;
          done_n = 1'b1;
          res_n  = RES_TIMEOUT;
          ext_n  = 1'b0;
          st_n   = ST_IDLE;
        end
      end
      ST_TERM_HS: begin
        if (ev_term_fin || expired) begin
          pins_n = PINS_IDLE;
          done_n = 1'b1;
          res_n  = ev_term_fin ? RES_OK : RES_IOERR;
          ext_n  = 1'b0;
          st_n   = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      pins   <= PINS_IDLE;
      dout   <= '0;
      done_q <= 1'b0;
      res_q  <= RES_OK;
      ext_q  <= 1'b0;
    end else begin
      st     <= st_n;
      pins   <= pins_n;
      dout   <= dout_n;
      done_q <= done_n;
      res_q  <= res_n;
      ext_q  <= ext_n;
    end
  end

  assign active        = (st != ST_IDLE);
  assign done          = done_q;
  assign result        = res_q;
  assign ext_mode      = ext_q;
  assign pdata         = dout;
  assign host_strobe_n = pins.strobe_n;
  assign host_feed_n   = pins.feed_n;
  assign host_init_n   = pins.init_n;
  assign host_sel_n    = pins.sel_n;

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_strobe_needs_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pins.strobe_n |-> pins.sel_n);

  assert_sel_high_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && neg_req && !term_req && pins.sel_n)
      |=> (done_q && res_q == RES_IOERR && $stable(dout) && $stable(pins)));

  assert_fail_to_compat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && (res_q == RES_REFUSED || res_q == RES_TIMEOUT))
      |-> (!ext_q && !pins.sel_n && pins.feed_n && pins.strobe_n));

  assert_term_clears_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TERM_HS && ev_term_fin) |=> (done_q && !ext_q && pins.feed_n));

  assert_idle_on_done_R14: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (st == ST_IDLE));
endmodule

// File: tb/tb_p1284_negotiator.sv
module tb_p1284_negotiator;
  localparam int P = 4;
  localparam int TS = 1;
  localparam int TR = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic neg_req = 1'b0;
  logic [7:0] neg_mode = 8'h00;
  logic term_req = 1'b0;
  logic active, done, ext_mode;
  logic [1:0] result;
  logic [7:0] pdata;
  logic host_strobe_n, host_feed_n, host_init_n, host_sel_n;
  logic dev_ack_n = 1'b1, dev_busy = 1'b0, dev_paper_err = 1'b0;
  logic dev_online = 1'b0, dev_fault_n = 1'b1;

  always #10 clk = ~clk;

  p1284_negotiator #(.PRESCALE(P), .T_SETUP(TS), .T_RESP(TR)) dut (
    .clk(clk), .rst_n(rst_n), .neg_req(neg_req), .neg_mode(neg_mode),
    .term_req(term_req), .active(active), .done(done), .result(result),
    .ext_mode(ext_mode), .pdata(pdata), .host_strobe_n(host_strobe_n),
    .host_feed_n(host_feed_n), .host_init_n(host_init_n), .host_sel_n(host_sel_n),
    .dev_ack_n(dev_ack_n), .dev_busy(dev_busy), .dev_paper_err(dev_paper_err),
    .dev_online(dev_online), .dev_fault_n(dev_fault_n)
  );

  // peripheral model; cfg: p_mode 0 normal, 1 silent, 2 no final ack
  // p_term 0 normal, 1 no busy answer, 2 no ack answer
  logic p_clear = 1'b0;
  int   p_mode = 0, p_term = 0, pst = 0;
  logic p_sel = 1'b1, saw = 1'b0;

  always @(negedge clk) begin
    if (!rst_n || p_clear) begin
      dev_ack_n = 1'b1; dev_busy = 1'b0; dev_paper_err = 1'b0;
      dev_online = 1'b0; dev_fault_n = 1'b1; pst = 0; saw = 1'b0;
    end else begin
      case (pst)
        0: if (host_sel_n && !host_feed_n && p_mode != 1) begin
             dev_ack_n = 1'b0; dev_paper_err = 1'b1; dev_online = 1'b1;
             dev_fault_n = 1'b1; pst = 1; saw = 1'b0;
           end
        1: begin
             if (!host_strobe_n) saw = 1'b1;
             if (saw && host_strobe_n && host_feed_n && p_mode != 2) begin
               dev_ack_n = 1'b1; dev_online = p_sel; dev_paper_err = 1'b0; pst = 2;
             end
           end
        2: if (!host_sel_n && host_feed_n && p_term != 1) begin
             dev_busy = 1'b1; dev_fault_n = 1'b1; dev_ack_n = 1'b0; pst = 3;
           end
        3: if (!host_feed_n && p_term != 2) begin
             dev_ack_n = 1'b1; pst = 4;
           end
        4: if (host_feed_n) begin
             dev_busy = 1'b0; dev_online = 1'b0; pst = 0;
           end
        default: pst = 0;
      endcase
    end
  end

  int tests = 0, fails = 0;

  task automatic step; @(posedge clk); #1; endtask

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic periph(input int m, input bit s, input int t);
    p_mode = m; p_sel = s; p_term = t;
    p_clear = 1'b1; step; step; p_clear = 1'b0; step;
  endtask

  // run bookkeeping
  int   n_done, sw_low, res_v;
  logic sel_hi, data2_sel, act2, inj = 1'b0;
  logic [7:0] data2;

  task automatic run(input bit dn, input bit dt, input logic [7:0] m);
    neg_mode = m; neg_req = dn; term_req = dt;
    step;
    neg_req = 1'b0; term_req = 1'b0;
    n_done = 1; sw_low = 0; sel_hi = 1'b0;
    data2 = pdata; data2_sel = host_sel_n; act2 = active;
    while (!done && n_done < 1000) begin
      if (!host_strobe_n) sw_low++;
      if (host_sel_n) sel_hi = 1'b1;
      if (n_done == 2) begin data2 = pdata; data2_sel = host_sel_n; act2 = active; end
      if (inj && n_done == 3) begin neg_req = 1'b1; term_req = 1'b1; end
      step;
      neg_req = 1'b0; term_req = 1'b0;
      n_done++;
    end
    res_v = int'(result);
  endtask

  task automatic chk_idle_pins(input string rq);
    chk(host_strobe_n && host_feed_n && host_init_n && !host_sel_n, rq, "idle pins",
        {host_strobe_n, host_feed_n, host_init_n, host_sel_n}, 4'b1110);
  endtask

  task automatic t_reset;
    chk_idle_pins("R1");
    chk(pdata == 8'h00, "R1", "pdata", pdata, 0);
    chk(!done && !active && !ext_mode, "R1", "status", {done, active, ext_mode}, 0);
  endtask

  task automatic t_nibble_and_repeat;
    logic [7:0] d0;
    periph(0, 1'b0, 0);
    run(1'b1, 1'b0, 8'h00);
    chk(data2 == 8'h00 && !data2_sel, "R3", "data before sel", {data2_sel, data2}, 0);
    chk(act2, "R14", "active mid-run", act2, 1);
    chk(sw_low >= P && sw_low <= P + 1, "R5", "strobe width", sw_low, P);
    chk(res_v == 0 && ext_mode, "R7", "nibble accept w/o online", {ext_mode, res_v[1:0]}, 3'b100);
    chk(host_sel_n && host_feed_n && host_strobe_n && host_init_n, "R3", "ext pins",
        {host_strobe_n, host_feed_n, host_init_n, host_sel_n}, 4'hF);
    chk(!active, "R14", "active at done", active, 0);
    step;
    chk(!done, "R12", "done pulse", done, 0);
    d0 = pdata;
    run(1'b1, 1'b0, 8'h5A);
    chk(n_done == 1 && res_v == 3, "R2", "abort code/cycle", n_done * 16 + res_v, 19);
    chk(pdata == d0 && host_sel_n && host_feed_n && host_strobe_n && ext_mode, "R2",
        "untouched", pdata, d0);
    step;
    chk(!done, "R12", "done pulse abort", done, 0);
    run(1'b0, 1'b1, 8'h00);
    chk(res_v == 0 && !ext_mode, "R9", "terminate", {ext_mode, res_v[1:0]}, 0);
    chk_idle_pins("R9");
  endtask

  task automatic t_ecp_ok;
    periph(0, 1'b1, 0);
    run(1'b1, 1'b0, 8'h30);
    chk(res_v == 0 && ext_mode && pdata == 8'h30, "R7", "ecp accept", res_v, 0);
    run(1'b0, 1'b1, 8'h00);
    chk(res_v == 0 && !ext_mode, "R9", "ecp terminate", res_v, 0);
  endtask

  task automatic t_refused;
    periph(0, 1'b0, 0);
    run(1'b1, 1'b0, 8'h30);
    chk(res_v == 1, "R7", "refused", res_v, 1);
    chk(!ext_mode, "R8", "ext after refuse", ext_mode, 0);
    chk_idle_pins("R8");
  endtask

  task automatic t_silent;
    int lo;
    lo = (2 * TS + TR) * P;
    periph(1, 1'b1, 0);
    run(1'b1, 1'b0, 8'h30);
    chk(res_v == 2, "R4", "timeout code", res_v, 2);
    chk(n_done >= lo && n_done <= lo + 6, "R4", "timeout cycle", n_done, lo + 3);
    chk_idle_pins("R8");
    chk(!ext_mode, "R8", "ext after timeout", ext_mode, 0);
  endtask

  task automatic t_no_final_ack;
    periph(2, 1'b1, 0);
    run(1'b1, 1'b0, 8'h30);
    chk(res_v == 3 && !ext_mode, "R6", "no ack io error", res_v, 3);
  endtask

  task automatic t_term_fail;
    periph(0, 1'b1, 1);
    run(1'b1, 1'b0, 8'h00);
    chk(res_v == 0, "R10", "setup negotiate", res_v, 0);
    run(1'b0, 1'b1, 8'h00);
    chk(res_v == 2 && !ext_mode, "R10", "term timeout", res_v, 2);
    chk_idle_pins("R10");
    periph(0, 1'b1, 2);
    run(1'b1, 1'b0, 8'h00);
    chk(res_v == 0, "R11", "setup negotiate", res_v, 0);
    run(1'b0, 1'b1, 8'h00);
    chk(res_v == 3 && !ext_mode && host_feed_n, "R11", "term io error", res_v, 3);
  endtask

  task automatic t_both_same_cycle;
    logic [7:0] d0;
    periph(0, 1'b1, 0);
    d0 = pdata;
    run(1'b1, 1'b1, 8'hA7);
    chk(res_v == 2, "R13", "termination chosen", res_v, 2);
    chk(pdata == d0 && !sel_hi, "R13", "no negotiation", {sel_hi, pdata}, {1'b0, d0});
  endtask

  task automatic t_ignore_busy;
    periph(0, 1'b1, 0);
    inj = 1'b1;
    run(1'b1, 1'b0, 8'h30);
    inj = 1'b0;
    chk(res_v == 0 && ext_mode, "R12", "requests ignored while active", res_v, 0);
    step;
    chk(!done && !active, "R12", "no second op", {done, active}, 0);
    run(1'b0, 1'b1, 8'h00);
    chk(res_v == 0 && !ext_mode, "R9", "cleanup terminate", res_v, 0);
  endtask

  initial begin
    repeat (3) step;
    t_reset;
    rst_n = 1'b1;
    step;
    t_reset;
    t_nibble_and_repeat;
    t_ecp_ok;
    t_refused;
    t_silent;
    t_no_final_ack;
    t_term_fail;
    t_both_same_cycle;
    t_ignore_busy;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule